// File: doc/BRIEF.md
# Exclusive Reservation Granule Monitor

This block keeps track of load-exclusive / store-exclusive reservations for a small set of requesters, one reservation each. A load-exclusive from a requester records that requester's reservation as the upper address bits above a power-of-two granule. The granule is `2**GRAN_LOG2` bytes, with GRAN_LOG2 from 3 to 11, so from 8 to 2048 bytes. A later store-exclusive from the same requester succeeds only if that reservation is still live and its address falls in the same granule. The address may differ anywhere below the granule boundary. A successful store-exclusive raises a write enable for the memory path that sits outside this block.

Reservations are lost in several ways. Any store-exclusive attempt consumes the reservation. A clear-exclusive request drops it. A write seen on the snoop port from another agent drops every reservation that covers the written granule. Exclusive accesses must be 32-bit word aligned, and a misaligned one is refused with a fault. Cache-line alignment plays no part.

Top module: `excl_granule_monitor`

## Requirements
- R1: After reset no requester holds a reservation and `rspValid` is 0; a store-exclusive issued first after reset fails.
- R2: An aligned load-exclusive (op 2'b01) stores tag `reqAddr[31:GRAN_LOG2]` as a live reservation for `reqId`, replacing any earlier one; its response is fail 0, write enable 0, fault 0.
- R3: An aligned store-exclusive (op 2'b10) succeeds, giving fail 0 and write enable 1, when the requester's reservation is live and its tag equals `reqAddr[31:GRAN_LOG2]`; low address bits inside the granule are ignored.
- R4: An aligned store-exclusive without a live matching reservation gives fail 1 and write enable 0.
- R5: Every aligned store-exclusive drops the requester's reservation, whether it succeeds or fails.
- R6: A clear-exclusive (op 2'b11) drops the requester's reservation, whatever its address; its response is fail 0, write enable 0, fault 0.
- R7: A snoop write (`snoopValid`) drops every reservation whose tag equals `snoopAddr[31:GRAN_LOG2]`; other reservations are kept.
- R8: A load- or store-exclusive with `reqAddr[1:0]` not zero gives fault 1, fail 1, write enable 0, and leaves all reservations unchanged.
- R9: The response is registered: it appears the clock after the request. Op 2'b00, or `reqValid` low, gives no response and changes no reservation.
- R10: When a snoop write and a store-exclusive to the same granule fall in the same cycle, the store fails. When a snoop write and a load-exclusive to the same granule fall in the same cycle, the new reservation is kept.
- R11: Reservations of different requesters are independent. A request only reads or changes the entry selected by `reqId`, apart from snoop effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | 00 none, 01 load-exclusive, 10 store-exclusive, 11 clear-exclusive |
| reqId | input | ID_W | Requester index |
| reqAddr | input | 32 | Byte address of the request |
| snoopValid | input | 1 | A write by another agent is seen |
| snoopAddr | input | 32 | Address of that write |
| rspValid | output | 1 | Response strobe, one clock after the request |
| rspFail | output | 1 | Status: 0 success, 1 failure |
| rspWriteEn | output | 1 | Store-exclusive may write memory |
| rspFault | output | 1 | Misaligned exclusive access |

## Verification
A snoop write and a request can land in the same cycle. The case that matters most is a store-exclusive whose granule is hit by that snoop. The bench provokes this with directed cycles that drive a matching snoop together with a store or a load. It also draws snoop and request addresses from a pool of only a few granules, so random traffic hits the same case often. A reference model judges each response. In that model the snoop is applied to the old state, it makes a same-cycle store fail, and a same-cycle load sets its reservation after the snoop has been applied.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_CLEAR = 2'b11
  } exOp_e;

  // control -> datapath strobes for the selected requester entry
  typedef struct packed {
    logic setRes;   // record a new reservation
    logic dropRes;  // invalidate the reservation
  } monStrobe_t;
endpackage

// File: rtl/excl_mon_ctrl.sv
module excl_mon_ctrl
  import excl_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [1:0] reqAddrLow,
  input  logic       resHit,
  output monStrobe_t strb,
  output logic       rspValid,
  output logic       rspFail,
  output logic       rspWriteEn,
  output logic       rspFault
);
  exOp_e op;
  logic  aligned;
  logic  isExcl;
  logic  isLoad;
  logic  isStore;
  logic  isClear;

  assign op      = exOp_e'(reqOp);
  assign aligned = (reqAddrLow == 2'b00);
  assign isLoad  = reqValid && (op == OP_LOAD);
  assign isStore = reqValid && (op == OP_STORE);
  assign isClear = reqValid && (op == OP_CLEAR);
  assign isExcl  = isLoad || isStore;

  always_comb begin
    strb         = '0;
    strb.setRes  = isLoad && aligned;
    strb.dropRes = (isStore && aligned) || isClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspFail    <= 1'b0;
      rspWriteEn <= 1'b0;
      rspFault   <= 1'b0;
    end else begin
      rspValid   <= isExcl || isClear;
      rspFault   <= isExcl && !aligned;
      rspWriteEn <= isStore && aligned && resHit;
      rspFail    <= (isExcl && !aligned) || (isStore && aligned && !resHit);
    end
  end
endmodule

// File: rtl/excl_mon_datapath.sv
module excl_mon_datapath
  import excl_mon_pkg::*;
#(
  parameter int GRAN_LOG2 = 4,
  parameter int ID_W      = 2,
  localparam int NUM_REQ  = 1 << ID_W,
  localparam int TAG_W    = 32 - GRAN_LOG2
) (
  input  logic             clk,
  input  logic             rstN,
  input  monStrobe_t       strb,
  input  logic [ID_W-1:0]  reqId,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             snoopValid,
  input  logic [TAG_W-1:0] snoopTag,
  output logic             resHit
);
  logic             validQ [NUM_REQ];
  logic [TAG_W-1:0] tagQ   [NUM_REQ];
  logic             snoopSameGran;

  assign snoopSameGran = snoopValid && (snoopTag == reqTag);

  for (genvar i = 0; i < NUM_REQ; i++) begin : gEntry
    logic selected;
    logic snoopKill;
    assign selected  = (reqId == ID_W'(i));
    assign snoopKill = snoopValid && validQ[i] && (tagQ[i] == snoopTag);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        tagQ[i]   <= '0;
      end else if (strb.setRes && selected) begin
        validQ[i] <= 1'b1;   // new reservation wins over a same-cycle snoop
        tagQ[i]   <= reqTag;
      end else if ((strb.dropRes && selected) || snoopKill) begin
        validQ[i] <= 1'b0;
      end
    end
  end

  // a same-cycle conflicting write is ordered before the store
  assign resHit = validQ[reqId] && (tagQ[reqId] == reqTag) && !snoopSameGran;
endmodule

// File: rtl/excl_granule_monitor.sv
module excl_granule_monitor
  import excl_mon_pkg::*;
#(
  parameter int GRAN_LOG2 = 4,
  parameter int ID_W      = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [1:0]      reqOp,
  input  logic [ID_W-1:0] reqId,
  input  logic [31:0]     reqAddr,
  input  logic            snoopValid,
  input  logic [31:0]     snoopAddr,
  output logic            rspValid,
  output logic            rspFail,
  output logic            rspWriteEn,
  output logic            rspFault
);
  localparam int TAG_W = 32 - GRAN_LOG2;

  monStrobe_t strb;
  logic       resHit;
  logic       unusedLowBits;

  assign unusedLowBits = ^{reqAddr[GRAN_LOG2-1:2], snoopAddr[GRAN_LOG2-1:0]};

  excl_mon_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .reqAddrLow (reqAddr[1:0]),
    .resHit     (resHit),
    .strb       (strb),
    .rspValid   (rspValid),
    .rspFail    (rspFail),
    .rspWriteEn (rspWriteEn),
    .rspFault   (rspFault)
  );

  excl_mon_datapath #(.GRAN_LOG2(GRAN_LOG2), .ID_W(ID_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqId      (reqId),
    .reqTag     (reqAddr[31:32-TAG_W]),
    .snoopValid (snoopValid),
    .snoopTag   (snoopAddr[31:32-TAG_W]),
    .resHit     (resHit)
  );
endmodule

// File: rtl/excl_granule_monitor_chk.sv
module excl_granule_monitor_chk #(
  parameter int GRAN_LOG2 = 4,
  parameter int ID_W      = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [1:0]      reqOp,
  input logic [ID_W-1:0] reqId,
  input logic [31:0]     reqAddr,
  input logic            snoopValid,
  input logic [31:0]     snoopAddr,
  input logic            rspValid,
  input logic            rspFail,
  input logic            rspWriteEn,
  input logic            rspFault
);
  logic exclReq;
  logic alignedStore;
  assign exclReq      = reqValid && (reqOp == 2'b01 || reqOp == 2'b10);
  assign alignedStore = reqValid && reqOp == 2'b10 && reqAddr[1:0] == 2'b00;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp != 2'b00) |=> rspValid);  // R9
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqOp != 2'b00) |=> !rspValid);  // R9
  AST_MISALIGN_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (exclReq && reqAddr[1:0] != 2'b00) |=> (rspFault && rspFail && !rspWriteEn));  // R8
  AST_WRITE_MEANS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    rspWriteEn |-> (rspValid && !rspFail && !rspFault));  // R3
  AST_STORE_CONSUMES: assert property (@(posedge clk) disable iff (!rstN)
    (alignedStore && $past(alignedStore) && $past(reqId) == reqId && $past(rstN))
    |=> (rspFail && !rspWriteEn));  // R5
  AST_SNOOP_BEATS_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (alignedStore && snoopValid && snoopAddr[31:GRAN_LOG2] == reqAddr[31:GRAN_LOG2])
    |=> rspFail);  // R10
endmodule

bind excl_granule_monitor excl_granule_monitor_chk #(.GRAN_LOG2(GRAN_LOG2), .ID_W(ID_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqId(reqId),
  .reqAddr(reqAddr), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
  .rspValid(rspValid), .rspFail(rspFail), .rspWriteEn(rspWriteEn), .rspFault(rspFault)
);

// File: tb/tb_excl_granule_monitor.sv
module tb_excl_granule_monitor;
  localparam int G    = 4;
  localparam int ID_W = 2;
  localparam int NREQ = 1 << ID_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'b00;
  logic [ID_W-1:0] reqId = '0;
  logic [31:0] reqAddr = '0;
  logic snoopValid = 1'b0;
  logic [31:0] snoopAddr = '0;
  logic rspValid, rspFail, rspWriteEn, rspFault;

  int nChecks = 0;
  int nFails  = 0;
  bit refValid [NREQ];
  logic [31:0] refTag [NREQ];

  always #5 clk = ~clk;

  excl_granule_monitor #(.GRAN_LOG2(G), .ID_W(ID_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqId(reqId),
    .reqAddr(reqAddr), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .rspValid(rspValid), .rspFail(rspFail), .rspWriteEn(rspWriteEn), .rspFault(rspFault)
  );

  function automatic logic [31:0] tagOf(logic [31:0] a);
    return a >> G;
  endfunction

  // expected {valid, fail, writeEn, fault}; also advances the reference model
  function automatic logic [3:0] modelStep(bit v, logic [1:0] op, int id, logic [31:0] a,
                                          bit sv, logic [31:0] sa);
    logic [3:0] e = 4'b0000;
    bit al = (a[1:0] == 2'b00);
    bit hit;
    if (v && op != 2'b00) e[3] = 1'b1;
    if (v && (op == 2'b01 || op == 2'b10) && !al) e = 4'b1101;
    else if (v && op == 2'b10) begin
      hit = refValid[id] && refTag[id] == tagOf(a) && !(sv && tagOf(sa) == tagOf(a));
      e = hit ? 4'b1010 : 4'b1100;
    end
    for (int i = 0; i < NREQ; i++)
      if (sv && refValid[i] && refTag[i] == tagOf(sa)) refValid[i] = 1'b0;
    if (v && al && op == 2'b01) begin refValid[id] = 1'b1; refTag[id] = tagOf(a); end
    if (v && ((op == 2'b10 && al) || op == 2'b11)) refValid[id] = 1'b0;
    return e;
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act = {rspValid, rspFail, rspWriteEn, rspFault};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {valid,fail,we,fault} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(string req, bit v, logic [1:0] op, int id, logic [31:0] a,
                      bit sv, logic [31:0] sa);
    logic [3:0] e;
    reqValid = v; reqOp = op; reqId = ID_W'(id); reqAddr = a;
    snoopValid = sv; snoopAddr = sa;
    e = modelStep(v, op, id, a, sv, sa);
    @(negedge clk);
    check(req, e);
  endtask

  function automatic logic [31:0] pickAddr();
    logic [31:0] a = 32'h0000_4000 + ({30'd0, 2'($urandom)} << G) + (($urandom % 4) << 2);
    if ($urandom % 8 == 0) a[1:0] = 2'($urandom % 3 + 1);
    return a;
  endfunction

  initial begin
    #(200000 * 10);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREQ; i++) begin refValid[i] = 1'b0; refTag[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset", 4'b0000);
    step("R1 store after reset", 1, 2'b10, 0, 32'h100, 0, 0);
    // R2 replace, R3 same granule different offset
    step("R2 load", 1, 2'b01, 0, 32'h100, 0, 0);
    step("R2 load replace", 1, 2'b01, 0, 32'h200, 0, 0);
    step("R4 old granule", 1, 2'b10, 0, 32'h104, 0, 0);
    step("R2 load", 1, 2'b01, 0, 32'h200, 0, 0);
    step("R3 offset in granule", 1, 2'b10, 0, 32'h20C, 0, 0);
    step("R5 consumed", 1, 2'b10, 0, 32'h200, 0, 0);
    // R6 clear with odd address
    step("R2 load", 1, 2'b01, 1, 32'h300, 0, 0);
    step("R6 clear", 1, 2'b11, 1, 32'h303, 0, 0);
    step("R6 store after clear", 1, 2'b10, 1, 32'h300, 0, 0);
    // R7 snoop match and miss
    step("R2 load", 1, 2'b01, 2, 32'h400, 0, 0);
    step("R2 load", 1, 2'b01, 3, 32'h500, 0, 0);
    step("R7 snoop", 0, 2'b00, 0, 0, 1, 32'h408);
    step("R7 killed", 1, 2'b10, 2, 32'h400, 0, 0);
    step("R7 kept", 1, 2'b10, 3, 32'h500, 0, 0);
    // R8 misaligned leaves reservation
    step("R2 load", 1, 2'b01, 0, 32'h600, 0, 0);
    step("R8 misaligned store", 1, 2'b10, 0, 32'h602, 0, 0);
    step("R8 misaligned load", 1, 2'b01, 0, 32'h701, 0, 0);
    step("R8 reservation intact", 1, 2'b10, 0, 32'h600, 0, 0);
    // R9 op none
    step("R2 load", 1, 2'b01, 1, 32'h800, 0, 0);
    step("R9 op none", 1, 2'b00, 1, 32'h900, 0, 0);
    step("R9 idle", 0, 2'b10, 1, 32'h800, 0, 0);
    step("R9 reservation intact", 1, 2'b10, 1, 32'h800, 0, 0);
    // R10 same-cycle collisions
    step("R2 load", 1, 2'b01, 2, 32'hA00, 0, 0);
    step("R10 store with snoop", 1, 2'b10, 2, 32'hA00, 1, 32'hA04);
    step("R10 load with snoop", 1, 2'b01, 2, 32'hB00, 1, 32'hB08);
    step("R10 load kept", 1, 2'b10, 2, 32'hB04, 0, 0);
    // R11 independence
    step("R2 load", 1, 2'b01, 0, 32'hC00, 0, 0);
    step("R11 other id", 1, 2'b10, 1, 32'hC00, 0, 0);
    step("R11 own id", 1, 2'b10, 0, 32'hC00, 0, 0);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit v = ($urandom % 5 != 0);
      logic [1:0] op = 2'($urandom);
      bit sv = ($urandom % 4 == 0);
      step("R2/R3/R4/R7/R10 random", v, op, int'($urandom % NREQ), pickAddr(), sv, pickAddr());
    end
    reqValid = 1'b0; snoopValid = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule